// File: doc/BRIEF.md
# SMBus Host Register and Status Unit

This unit is the software-facing register file of a small SMBus host controller, reached over a byte-wide register port. Software fills in the target address, command byte, data bytes, a 16-bit bus clock divider and up to 32 bytes of block payload. It then writes the control byte with the launch bit set. The unit hands a one-cycle launch pulse and the protocol type to a separate transaction sequencer. It presents all register contents to that sequencer and records how the transfer ended in a sticky status nibble.

While a transfer is running, host writes to the transfer registers are dropped, so the sequencer sees stable operands. The sequencer may still write received bytes into the two data registers and the block buffer. Status bits stay set until software clears them by writing ones. A new launch is refused while any status bit is pending.

Top module: `smbus_host_regs`

## Requirements
- R1: After a synchronous reset, every register reads 0, `seq_start` is low and the status nibble is 0.
- R2: Register offsets: control 0x00, status 0x01, divider low 0x02, divider high 0x03, target address 0x04, command 0x05, data0 0x06, data1 0x07, and block buffer entries 0..31 at 0x20..0x3F. Read data appears one clock after the address is presented. Unmapped offsets read 0. Control bit 4 always reads 0.
- R3: A write to control with bit 4 = 1 launches a transfer when the status nibble is 0 and bits 2:0 hold a supported type: 0 quick, 1 byte, 2 byte-data, 3 word, 5 block. On the next cycle status bit 3 (busy) is 1, `seq_start` pulses for exactly one cycle and `seq_proto` equals the type.
- R4: A launch with type 4, 6 or 7 produces no `seq_start` pulse, leaves busy at 0 and sets status bit 1 (no response) on the next cycle.
- R5: A launch request is ignored while any status bit is set: no pulse occurs and the status is unchanged.
- R6: While busy, `seq_done` clears busy and sets exactly one result bit. Bit 2 (collision) is set if `seq_coll` is high. Otherwise bit 1 (no response) is set if `seq_nack` is high. Otherwise bit 0 (complete) is set. While busy, bits 2:0 are 0.
- R7: Writing the status register clears every status bit written as 1 and leaves the others unchanged. A result bit set by `seq_done` in the same cycle survives the clear.
- R8: While busy, host writes to control, divider, address, command, data0, data1 and the block buffer are ignored.
- R9: While busy, `seq_dat_we[0]` loads data0 from `seq_dat_wdata[7:0]`, `seq_dat_we[1]` loads data1 from `seq_dat_wdata[15:8]`, and `seq_buf_we` writes the buffer entry `seq_buf_idx`. `seq_buf_rdata` returns entry `seq_buf_idx` one clock later.
- R10: `seq_target`, `seq_cmd`, `seq_data0`, `seq_data1` and `seq_clkdiv` (high byte from offset 0x03) always equal the stored register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the address |
| seq_start | output | 1 | One-cycle launch pulse to the sequencer |
| seq_proto | output | 3 | Protocol type from control bits 2:0 |
| seq_target | output | 8 | Target address byte (address in 7:1, read flag in 0) |
| seq_cmd | output | 8 | Command byte |
| seq_data0 | output | 8 | Data0 (low byte or block count) |
| seq_data1 | output | 8 | Data1 (high byte) |
| seq_clkdiv | output | 16 | Bus clock divider |
| seq_done | input | 1 | Sequencer finished the transfer |
| seq_coll | input | 1 | Transfer ended in a bus collision (with seq_done) |
| seq_nack | input | 1 | Target did not respond (with seq_done) |
| seq_dat_we | input | 2 | Sequencer write enables for data0 and data1 |
| seq_dat_wdata | input | 16 | Sequencer data for data1:data0 |
| seq_buf_we | input | 1 | Sequencer write to the block buffer |
| seq_buf_idx | input | $clog2(BUF_DEPTH) | Sequencer buffer index |
| seq_buf_wdata | input | 8 | Sequencer buffer write data |
| seq_buf_rdata | output | 8 | Buffer entry at seq_buf_idx, one cycle later |

## Verification
The one collision of functions in the same cycle is a software status write landing on the same edge as the sequencer's `seq_done`. The first case is a write of 0x01 together with a clean finish. The second is a write of 0x08, which aims to clear busy, together with a collision finish. In both cases the status read afterwards must show only the freshly set result bit. Around this, the bench sweeps all eight type codes against the three finish outcomes and computes each expected status byte from the outcome priority. Every launch the design refuses, whether for a pending status or an unsupported code, is judged by counting launch pulses and reading status back.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h01;
  localparam int OFF_DIVL = 'h02;
  localparam int OFF_DIVH = 'h03;
  localparam int OFF_ADR  = 'h04;
  localparam int OFF_CMD  = 'h05;
  localparam int OFF_D0   = 'h06;
  localparam int OFF_D1   = 'h07;

  localparam int LAUNCH_BIT = 4;

  typedef enum logic [2:0] {
    PR_QUICK = 3'd0,
    PR_BYTE  = 3'd1,
    PR_BDATA = 3'd2,
    PR_WORD  = 3'd3,
    PR_BLOCK = 3'd5
  } proto_e;

  function automatic logic proto_ok(input logic [2:0] code);
    case (code)
      PR_QUICK, PR_BYTE, PR_BDATA, PR_WORD, PR_BLOCK: proto_ok = 1'b1;
      default:                                        proto_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  // single write port, two registered read ports: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/smbus_stat_ctl.sv
module smbus_stat_ctl
  import smbus_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       stat_wr,
  input  logic [3:0] stat_clr,
  input  logic       seq_done,
  input  logic       seq_coll,
  input  logic       seq_nack,
  output logic [7:0] ctrl_q,
  output logic [3:0] status,
  output logic       busy,
  output logic       seq_start
);

  logic coll_q, nack_q, cmpl_q;
  logic pending, launch, sup, fin;
  logic [3:0] clr;

  assign status  = {busy, coll_q, nack_q, cmpl_q};
  assign pending = |status;
  assign sup     = proto_ok(ctrl_wdata[2:0]);
  assign launch  = ctrl_wr && !busy && ctrl_wdata[LAUNCH_BIT] && !pending;
  assign fin     = busy && seq_done;
  assign clr     = stat_wr ? stat_clr : 4'b0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      busy      <= 1'b0;
      coll_q    <= 1'b0;
      nack_q    <= 1'b0;
      cmpl_q    <= 1'b0;
      seq_start <= 1'b0;
    end else begin
      seq_start <= launch && sup;
      if (ctrl_wr && !busy)
        ctrl_q <= ctrl_wdata & ~(8'd1 << LAUNCH_BIT);
      busy   <= (busy & ~clr[3] & ~fin) | (launch & sup);
      coll_q <= (coll_q & ~clr[2]) | (fin & seq_coll);
      nack_q <= (nack_q & ~clr[1]) | (fin & !seq_coll & seq_nack) | (launch & !sup);
      cmpl_q <= (cmpl_q & ~clr[0]) | (fin & !seq_coll & !seq_nack);
    end
  end

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> busy);
  p_type_ok_r4: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> proto_ok(ctrl_q[2:0]));
  p_start_guard_r5: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> $past(status) == 4'b0000);
  p_idle_clean_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(coll_q || nack_q || cmpl_q));
  p_done_one_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && seq_done) |=> (!busy && $countones({coll_q, nack_q, cmpl_q}) == 1));

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BUF_BASE  = 'h20,
  parameter int BUF_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic                         reg_wr,
  input  logic [7:0]                   reg_wdata,
  output logic [7:0]                   reg_rdata,
  output logic                         seq_start,
  output logic [2:0]                   seq_proto,
  output logic [7:0]                   seq_target,
  output logic [7:0]                   seq_cmd,
  output logic [7:0]                   seq_data0,
  output logic [7:0]                   seq_data1,
  output logic [15:0]                  seq_clkdiv,
  input  logic                         seq_done,
  input  logic                         seq_coll,
  input  logic                         seq_nack,
  input  logic [1:0]                   seq_dat_we,
  input  logic [15:0]                  seq_dat_wdata,
  input  logic                         seq_buf_we,
  input  logic [$clog2(BUF_DEPTH)-1:0] seq_buf_idx,
  input  logic [7:0]                   seq_buf_wdata,
  output logic [7:0]                   seq_buf_rdata
);

  localparam int IDX_W = $clog2(BUF_DEPTH);

  logic [7:0]       ctrl_q, adr_q, cmd_q, d0_q, d1_q;
  logic [15:0]      div_q;
  logic [3:0]       status;
  logic             busy;
  logic             in_buf, host_wr;
  logic [IDX_W-1:0] host_idx, buf_waddr;
  logic [7:0]       buf_wdata, buf_host_q, rd_next, rd_q;
  logic             buf_we, buf_sel_q;

  assign host_wr  = reg_wr && !busy;
  assign in_buf   = (int'(reg_addr) >= BUF_BASE) && (int'(reg_addr) < BUF_BASE + BUF_DEPTH);
  assign host_idx = IDX_W'(reg_addr - ADDR_W'(BUF_BASE));

  smbus_stat_ctl u_stat (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (reg_wr && int'(reg_addr) == OFF_CTRL),
    .ctrl_wdata (reg_wdata),
    .stat_wr    (reg_wr && int'(reg_addr) == OFF_STAT),
    .stat_clr   (reg_wdata[3:0]),
    .seq_done   (seq_done),
    .seq_coll   (seq_coll),
    .seq_nack   (seq_nack),
    .ctrl_q     (ctrl_q),
    .status     (status),
    .busy       (busy),
    .seq_start  (seq_start)
  );

  // operand registers: host owns them when idle, sequencer loads data when busy
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      adr_q <= '0;
      cmd_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else begin
      if (host_wr) begin
        case (int'(reg_addr))
          OFF_DIVL: div_q[7:0]  <= reg_wdata;
          OFF_DIVH: div_q[15:8] <= reg_wdata;
          OFF_ADR:  adr_q       <= reg_wdata;
          OFF_CMD:  cmd_q       <= reg_wdata;
          OFF_D0:   d0_q        <= reg_wdata;
          OFF_D1:   d1_q        <= reg_wdata;
          default: ;
        endcase
      end
      if (busy) begin
        if (seq_dat_we[0]) d0_q <= seq_dat_wdata[7:0];
        if (seq_dat_we[1]) d1_q <= seq_dat_wdata[15:8];
      end
    end
  end

  // busy selects who may write the buffer, so the two writers never meet
  assign buf_we    = busy ? seq_buf_we : (host_wr && in_buf);
  assign buf_waddr = busy ? seq_buf_idx : host_idx;
  assign buf_wdata = busy ? seq_buf_wdata : reg_wdata;

  smbus_blk_buf #(.DEPTH(BUF_DEPTH), .W(8)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (host_idx),
    .rdata_a (buf_host_q),
    .raddr_b (seq_buf_idx),
    .rdata_b (seq_buf_rdata)
  );

  always_comb begin
    case (int'(reg_addr))
      OFF_CTRL: rd_next = ctrl_q;
      OFF_STAT: rd_next = {4'b0000, status};
      OFF_DIVL: rd_next = div_q[7:0];
      OFF_DIVH: rd_next = div_q[15:8];
      OFF_ADR:  rd_next = adr_q;
      OFF_CMD:  rd_next = cmd_q;
      OFF_D0:   rd_next = d0_q;
      OFF_D1:   rd_next = d1_q;
      default:  rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      buf_sel_q <= 1'b0;
    end else begin
      rd_q      <= rd_next;
      buf_sel_q <= in_buf;
    end
  end

  assign reg_rdata  = buf_sel_q ? buf_host_q : rd_q;
  assign seq_proto  = ctrl_q[2:0];
  assign seq_target = adr_q;
  assign seq_cmd    = cmd_q;
  assign seq_data0  = d0_q;
  assign seq_data1  = d1_q;
  assign seq_clkdiv = div_q;

  p_regs_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(adr_q) && $stable(cmd_q) && $stable(div_q) && $stable(ctrl_q)));
  p_ctrl_launch_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[LAUNCH_BIT] == 1'b0);

endmodule

// File: tb/test_smbus_host_regs.sv
module test_smbus_host_regs;

  localparam int A_CTRL = 'h00, A_STAT = 'h01, A_DIVL = 'h02, A_DIVH = 'h03;
  localparam int A_ADR = 'h04, A_CMD = 'h05, A_D0 = 'h06, A_D1 = 'h07, A_BUF = 'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        seq_start;
  logic [2:0]  seq_proto;
  logic [7:0]  seq_target, seq_cmd, seq_data0, seq_data1;
  logic [15:0] seq_clkdiv;
  logic        seq_done = 1'b0, seq_coll = 1'b0, seq_nack = 1'b0;
  logic [1:0]  seq_dat_we = '0;
  logic [15:0] seq_dat_wdata = '0;
  logic        seq_buf_we = 1'b0;
  logic [4:0]  seq_buf_idx = '0;
  logic [7:0]  seq_buf_wdata = '0;
  logic [7:0]  seq_buf_rdata;

  int n_chk = 0, n_bad = 0, nstart = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  smbus_host_regs i_smbus_host_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .seq_start(seq_start), .seq_proto(seq_proto),
    .seq_target(seq_target), .seq_cmd(seq_cmd), .seq_data0(seq_data0),
    .seq_data1(seq_data1), .seq_clkdiv(seq_clkdiv), .seq_done(seq_done),
    .seq_coll(seq_coll), .seq_nack(seq_nack), .seq_dat_we(seq_dat_we),
    .seq_dat_wdata(seq_dat_wdata), .seq_buf_we(seq_buf_we), .seq_buf_idx(seq_buf_idx),
    .seq_buf_wdata(seq_buf_wdata), .seq_buf_rdata(seq_buf_rdata)
  );

  always @(negedge clk) if (!rst && seq_start) nstart++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 50000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = 6'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr = 6'(a);
    @(negedge clk); v = int'(reg_rdata);
  endtask

  task automatic finish_ev(input bit c, input bit n);
    @(negedge clk); seq_done = 1'b1; seq_coll = c; seq_nack = n;
    @(negedge clk); seq_done = 1'b0; seq_coll = 1'b0; seq_nack = 1'b0;
  endtask

  task automatic finish_with_clear(input bit c, input int d);
    @(negedge clk); seq_done = 1'b1; seq_coll = c;
    reg_addr = 6'(A_STAT); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk); seq_done = 1'b0; seq_coll = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    int v, n0, a, exp_st;
    bit sup;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 seq_start", int'(seq_start), 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_CTRL, v); chk("R1 control", v, 0);
    chk("R1 divider", int'(seq_clkdiv), 0);
    chk("R1 target", int'(seq_target), 0);

    // R2 / R10 register map and sequencer view
    wr(A_DIVL, 'h2C); wr(A_DIVH, 'h01);
    chk("R10 clkdiv", int'(seq_clkdiv), 'h012C);
    rd(A_DIVL, v); chk("R2 div low", v, 'h2C);
    rd(A_DIVH, v); chk("R2 div high", v, 'h01);
    wr(A_D0, 'h34); wr(A_D1, 'h12);
    chk("R10 data0", int'(seq_data0), 'h34);
    chk("R10 data1", int'(seq_data1), 'h12);
    rd(A_D1, v); chk("R2 data1", v, 'h12);
    wr(A_CTRL, 'hEB); rd(A_CTRL, v);
    chk("R2 control launch bit reads 0", v, 'hEB);
    wr(A_CTRL, 'h00);
    rd('h10, v); chk("R2 unmapped offset", v, 0);
    for (int i = 0; i < 32; i++) wr(A_BUF + i, (i * 37 + 11) & 255);
    for (int i = 0; i < 32; i++) begin
      rd(A_BUF + i, v); chk("R2 buffer readback", v, (i * 37 + 11) & 255);
    end
    @(negedge clk); seq_buf_idx = 5'd5;
    @(negedge clk); chk("R9 sequencer buffer read", int'(seq_buf_rdata), (5 * 37 + 11) & 255);

    wr(A_CMD, 'h5A);

    // sweep every type code against every finish outcome
    for (int p = 0; p < 8; p++) begin
      for (int o = 0; o < 3; o++) begin
        sup = (p <= 3) || (p == 5);
        a = (p * 16 + o * 5 + 1) & 255;
        exp_st = (o == 0) ? 'h01 : (o == 1) ? 'h02 : 'h04;
        wr(A_ADR, a);
        rd(A_STAT, v);
        n0 = nstart;
        wr(A_CTRL, 'h10 | p);
        if (sup) begin
          chk("R3 launch pulse", int'(seq_start), 1);
          chk("R3 proto", int'(seq_proto), p);
          chk("R10 target", int'(seq_target), a);
          rd(A_STAT, v); chk("R3 busy", v, 'h08);
          chk("R3 pulse single", nstart - n0, 1);
          wr(A_CMD, 'hEE);
          wr(A_CTRL, 'h07);
          finish_ev(o == 2, o != 0);
          rd(A_STAT, v); chk("R6 result", v, exp_st);
          rd(A_CMD, v); chk("R8 command frozen", v, 'h5A);
          chk("R8 proto frozen", int'(seq_proto), p);
          n0 = nstart;
          wr(A_CTRL, 'h10 | p);
          rd(A_STAT, v); chk("R5 status kept", v, exp_st);
          chk("R5 no pulse", nstart - n0, 0);
          wr(A_STAT, ~exp_st & 'h0F);
          rd(A_STAT, v); chk("R7 other bits do nothing", v, exp_st);
          wr(A_STAT, exp_st);
          rd(A_STAT, v); chk("R7 cleared", v, 0);
        end else begin
          chk("R4 no pulse now", int'(seq_start), 0);
          rd(A_STAT, v); chk("R4 no-response", v, 'h02);
          chk("R4 no pulse", nstart - n0, 0);
          wr(A_STAT, 'h02);
          rd(A_STAT, v); chk("R7 cleared", v, 0);
        end
      end
    end

    // R9 sequencer data loads and R8 ignored host buffer write
    wr(A_CTRL, 'h13);
    @(negedge clk); seq_dat_we = 2'b11; seq_dat_wdata = 16'hBEEF;
    seq_buf_we = 1'b1; seq_buf_idx = 5'd7; seq_buf_wdata = 8'hA5;
    @(negedge clk); seq_dat_we = 2'b00; seq_buf_we = 1'b0;
    wr(A_BUF + 8, 'h00);
    wr(A_D0, 'h00);
    finish_ev(1'b0, 1'b0);
    rd(A_D0, v); chk("R9 data0 from sequencer", v, 'hEF);
    rd(A_D1, v); chk("R9 data1 from sequencer", v, 'hBE);
    rd(A_BUF + 7, v); chk("R9 buffer from sequencer", v, 'hA5);
    rd(A_BUF + 8, v); chk("R8 buffer frozen", v, (8 * 37 + 11) & 255);
    wr(A_STAT, 'h0F);

    // R7 same-cycle: finish and status clear on one edge
    wr(A_CTRL, 'h12);
    finish_with_clear(1'b0, 'h01);
    rd(A_STAT, v); chk("R7 complete survives clear", v, 'h01);
    wr(A_STAT, 'h01);
    wr(A_CTRL, 'h15);
    finish_with_clear(1'b1, 'h08);
    rd(A_STAT, v); chk("R7 collision survives busy clear", v, 'h04);
    wr(A_STAT, 'h04);
    rd(A_STAT, v); chk("R7 final clear", v, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule